// File: doc/BRIEF.md
# PCIe Configuration Access Router

This block sits between a local register bus and the two places where configuration space lives in a PCIe root-port subsystem. A configuration request names a bus, a device, a function and a byte offset. A request for bus zero is sent to the root port's own register window. A request for any other bus is sent to the remote configuration window, which starts at byte 0x1000. That strobe carries a routing word, which is also loaded into a setup register. The routing word packs the bus, device and function numbers together with an access-type flag. Bus 1 is the logical secondary bus and gets Type 0 accesses. Every bus above 1 gets Type 1.

The same register bus reaches a command/status register. Two of its bits are plain controls: the link-training enable and the outbound-translation enable. A third bit selects an alternate register view and lives in another clock domain. A change to that bit is carried across by a toggle handshake through two-flop synchronizers. The read-back of the bit changes only when the acknowledge has returned, so software can poll it to learn that the crossing is complete. A link-up flag is derived from the link state machine's 5-bit state code.

Top module: `pcie_cfg_router`

## Requirements
- R1: A configuration request with bus number 0 produces a one-cycle `loc_valid` pulse on the clock edge after `ca_valid`, with `loc_addr` equal to the offset and write flag and data passed through. No remote strobe is produced.
- R2: A request with a non-zero bus number produces a one-cycle `rem_valid` pulse on the edge after `ca_valid`, with `rem_addr` = 0x1000 + offset. No local strobe is produced.
- R3: The routing word holds the bus number in bits 23:16, the device number in bits 12:8 and the function number in bits 2:0. Bit 24 is 1 (Type 1) for every bus other than 1 and 0 for bus 1. All other bits are 0.
- R4: A remote request loads its routing word into the setup register (read at byte address 0x08). A bus-0 request leaves the setup register unchanged.
- R5: `rem_route` holds the word of the last remote request until the next remote request. A later register-bus write to the setup register does not change it.
- R6: The setup register can be written and read at address 0x08. When a register-bus write and a remote request reach it in the same cycle, the request's word is kept.
- R7: In the command register (address 0x04), bit 0 drives `train_en` and bit 1 drives `xlat_en`. Both read back as written. Bits other than 0, 1 and 5 read as 0.
- R8: Writing a new value to command bit 5 makes `view_sel_dst` follow it in the destination domain. Command bit 5 reads back the new value only once the acknowledge has returned, and never on the read directly after the write.
- R9: While a change of bit 5 is still in flight, writes to bit 5 are ignored. Bits 0 and 1 of the same write still take effect.
- R10: `link_up` is 1 one clock after `link_state` equals 0x11, and 0 one clock after any other code.
- R11: After reset every register reads 0 and every strobe is low. A read returns `reg_rvalid` and `reg_rdata` one cycle later. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| dst_clk | input | 1 | Clock of the alternate-view destination domain |
| dst_rst | input | 1 | Synchronous active-high reset, `dst_clk` domain |
| reg_valid | input | 1 | Register-bus access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| reg_rdata | output | 32 | Read data |
| ca_valid | input | 1 | Configuration request strobe |
| ca_write | input | 1 | Configuration request is a write |
| ca_bus | input | 8 | Target bus number |
| ca_dev | input | 5 | Target device number |
| ca_func | input | 3 | Target function number |
| ca_off | input | 12 | Byte offset within the function's space |
| ca_wdata | input | 32 | Configuration write data |
| loc_valid | output | 1 | Strobe to the local root-port window |
| loc_write | output | 1 | Local access is a write |
| loc_addr | output | 13 | Local window address |
| loc_wdata | output | 32 | Local write data |
| rem_valid | output | 1 | Strobe to the remote configuration window |
| rem_write | output | 1 | Remote access is a write |
| rem_addr | output | 13 | Remote window address (0x1000 + offset) |
| rem_wdata | output | 32 | Remote write data |
| rem_route | output | 32 | Routing word of the remote access |
| train_en | output | 1 | Link-training enable |
| xlat_en | output | 1 | Outbound-translation enable |
| view_sel_dst | output | 1 | Alternate-view select in the `dst_clk` domain |
| link_state | input | 5 | State code of the link state machine |
| link_up | output | 1 | Link is in its active state |

## Verification
The assertions assume that `link_state`, `reg_valid` and `ca_valid` are at defined, steady levels from the first clock of reset. They also assume that both resets are applied together, so the toggle registers on each side of the crossing start equal. The bench changes every input only at falling clock edges and holds both resets over several cycles of each clock. It polls the alternate-view bit through the register bus with a bounded count and does not assume a fixed crossing latency. It deliberately overlaps a setup-register write with a remote request, and a second view write with a crossing still in flight, because those are the cases the ordering rules cover.

// File: rtl/pcie_cfg_router_pkg.sv
package pcie_cfg_router_pkg;

  localparam int unsigned BUS_W   = 8;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned FUNC_W  = 3;
  localparam int unsigned ROUTE_W = 32;

  // routing-word layout, decoded by the remote window
  localparam int unsigned RT_FUNC_LSB  = 0;
  localparam int unsigned RT_DEV_LSB   = 8;
  localparam int unsigned RT_BUS_LSB   = 16;
  localparam int unsigned RT_TYPE1_BIT = 24;

  // register byte addresses
  localparam logic [7:0] CMD_OFS   = 8'h04;
  localparam logic [7:0] SETUP_OFS = 8'h08;

  // command register fields
  localparam int unsigned CMD_TRAIN_BIT = 0;
  localparam int unsigned CMD_XLAT_BIT  = 1;
  localparam int unsigned CMD_VIEW_BIT  = 5;

  localparam logic [4:0] LINK_UP_CODE = 5'h11;

  typedef struct packed {
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
  } bdf_t;

  function automatic logic [ROUTE_W-1:0] route_word(input bdf_t t);
    logic [ROUTE_W-1:0] w;
    w = '0;
    w[RT_BUS_LSB +: BUS_W]   = t.bus;
    w[RT_DEV_LSB +: DEV_W]   = t.dev;
    w[RT_FUNC_LSB +: FUNC_W] = t.func;
    w[RT_TYPE1_BIT]          = (t.bus != BUS_W'(1));
    return w;
  endfunction

endpackage

// File: rtl/pcie_cfg_steer.sv
module pcie_cfg_steer
  import pcie_cfg_router_pkg::*;
#(
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_AW = 13,
  parameter logic [CFG_AW-1:0] REMOTE_BASE = 13'h1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ca_valid,
  input  logic                ca_write,
  input  bdf_t                ca_bdf,
  input  logic [OFF_W-1:0]    ca_off,
  input  logic [DATA_W-1:0]   ca_wdata,
  output logic                loc_valid,
  output logic                loc_write,
  output logic [CFG_AW-1:0]   loc_addr,
  output logic [DATA_W-1:0]   loc_wdata,
  output logic                rem_valid,
  output logic                rem_write,
  output logic [CFG_AW-1:0]   rem_addr,
  output logic [DATA_W-1:0]   rem_wdata,
  output logic [ROUTE_W-1:0]  rem_route,
  output logic                setup_load,
  output logic [ROUTE_W-1:0]  setup_word
);

  logic is_local;

  always_comb begin
    is_local   = (ca_bdf.bus == '0);
    setup_load = ca_valid && !is_local;
    setup_word = route_word(ca_bdf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_valid <= 1'b0;
      loc_write <= 1'b0;
      loc_addr  <= '0;
      loc_wdata <= '0;
      rem_valid <= 1'b0;
      rem_write <= 1'b0;
      rem_addr  <= '0;
      rem_wdata <= '0;
      rem_route <= '0;
    end else begin
      loc_valid <= ca_valid && is_local;
      rem_valid <= setup_load;
      if (ca_valid && is_local) begin
        loc_write <= ca_write;
        loc_addr  <= CFG_AW'(ca_off);
        loc_wdata <= ca_wdata;
      end
      // the word travels with its own strobe and is held until the next one
      if (setup_load) begin
        rem_write <= ca_write;
        rem_addr  <= REMOTE_BASE + CFG_AW'(ca_off);
        rem_wdata <= ca_wdata;
        rem_route <= setup_word;
      end
    end
  end

endmodule

// File: rtl/pcie_cfg_regs.sv
module pcie_cfg_regs
  import pcie_cfg_router_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_rvalid,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               setup_load,
  input  logic [ROUTE_W-1:0] setup_word,
  input  logic               view_ack,
  output logic               view_wr_en,
  output logic               view_wr_val,
  output logic               train_en,
  output logic               xlat_en
);

  localparam logic [REG_AW-1:0] CMD_A   = REG_AW'(CMD_OFS);
  localparam logic [REG_AW-1:0] SETUP_A = REG_AW'(SETUP_OFS);

  logic [DATA_W-1:0] setup_q;
  logic [DATA_W-1:0] cmd_rd;
  logic              wr_cmd, wr_setup, rd_req;

  always_comb begin
    rd_req   = reg_valid && !reg_write;
    wr_cmd   = reg_valid && reg_write && (reg_addr == CMD_A);
    wr_setup = reg_valid && reg_write && (reg_addr == SETUP_A);
    view_wr_en  = wr_cmd;
    view_wr_val = reg_wdata[CMD_VIEW_BIT];
    cmd_rd = '0;
    cmd_rd[CMD_TRAIN_BIT] = train_en;
    cmd_rd[CMD_XLAT_BIT]  = xlat_en;
    cmd_rd[CMD_VIEW_BIT]  = view_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q    <= '0;
      train_en   <= 1'b0;
      xlat_en    <= 1'b0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_req;
      if (rd_req) begin
        if (reg_addr == CMD_A)        reg_rdata <= cmd_rd;
        else if (reg_addr == SETUP_A) reg_rdata <= setup_q;
        else                          reg_rdata <= '0;
      end
      // a request's word beats a simultaneous bus write
      if (setup_load)    setup_q <= DATA_W'(setup_word);
      else if (wr_setup) setup_q <= reg_wdata;
      if (wr_cmd) begin
        train_en <= reg_wdata[CMD_TRAIN_BIT];
        xlat_en  <= reg_wdata[CMD_XLAT_BIT];
      end
    end
  end

endmodule

// File: rtl/pcie_cfg_view_xfer.sv
module pcie_cfg_view_xfer #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dst_clk,
  input  logic dst_rst,
  input  logic wr_en,
  input  logic wr_val,
  output logic view_ack,
  output logic busy,
  output logic view_dst
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  // source side
  logic                   req_tgl, target, ack_seen;
  logic [SYNC_STAGES-1:0] ack_sync;
  // destination side
  logic [SYNC_STAGES-1:0] req_sync;
  logic                   dst_ack_tgl;

  assign busy = (req_tgl != ack_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl  <= 1'b0;
      target   <= 1'b0;
      ack_seen <= 1'b0;
      ack_sync <= '0;
      view_ack <= 1'b0;
    end else begin
      ack_sync <= {ack_sync[MSB-1:0], dst_ack_tgl};
      if (ack_sync[MSB] != ack_seen) begin
        ack_seen <= ack_sync[MSB];
        view_ack <= target;
      end
      if (wr_en && !busy && (wr_val != target)) begin
        target  <= wr_val;
        req_tgl <= ~req_tgl;
      end
    end
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      req_sync    <= '0;
      dst_ack_tgl <= 1'b0;
      view_dst    <= 1'b0;
    end else begin
      req_sync <= {req_sync[MSB-1:0], req_tgl};
      if (req_sync[MSB] != dst_ack_tgl) begin
        dst_ack_tgl <= req_sync[MSB];
        view_dst    <= ~view_dst;
      end
    end
  end

endmodule

// File: rtl/pcie_cfg_router.sv
module pcie_cfg_router
  import pcie_cfg_router_pkg::*;
#(
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned REMOTE_BASE = 32'h1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STATE_W     = 5,
  parameter logic [STATE_W-1:0] LINK_L0 = STATE_W'(LINK_UP_CODE),
  localparam int unsigned BASE_W = $clog2(REMOTE_BASE),
  localparam int unsigned CFG_AW = ((OFF_W > BASE_W) ? OFF_W : BASE_W) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dst_clk,
  input  logic               dst_rst,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_rvalid,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               ca_valid,
  input  logic               ca_write,
  input  logic [BUS_W-1:0]   ca_bus,
  input  logic [DEV_W-1:0]   ca_dev,
  input  logic [FUNC_W-1:0]  ca_func,
  input  logic [OFF_W-1:0]   ca_off,
  input  logic [DATA_W-1:0]  ca_wdata,
  output logic               loc_valid,
  output logic               loc_write,
  output logic [CFG_AW-1:0]  loc_addr,
  output logic [DATA_W-1:0]  loc_wdata,
  output logic               rem_valid,
  output logic               rem_write,
  output logic [CFG_AW-1:0]  rem_addr,
  output logic [DATA_W-1:0]  rem_wdata,
  output logic [ROUTE_W-1:0] rem_route,
  output logic               train_en,
  output logic               xlat_en,
  output logic               view_sel_dst,
  input  logic [STATE_W-1:0] link_state,
  output logic               link_up
);

  bdf_t               ca_bdf;
  logic               setup_load;
  logic [ROUTE_W-1:0] setup_word;
  logic               view_ack, view_busy, view_wr_en, view_wr_val;

  assign ca_bdf = '{bus: ca_bus, dev: ca_dev, func: ca_func};

  pcie_cfg_steer #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW),
    .REMOTE_BASE(CFG_AW'(REMOTE_BASE))
  ) i_steer (
    .clk(clk), .rst(rst),
    .ca_valid(ca_valid), .ca_write(ca_write), .ca_bdf(ca_bdf),
    .ca_off(ca_off), .ca_wdata(ca_wdata),
    .loc_valid(loc_valid), .loc_write(loc_write), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .rem_valid(rem_valid), .rem_write(rem_write), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
    .rem_route(rem_route), .setup_load(setup_load), .setup_word(setup_word)
  );

  pcie_cfg_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .setup_load(setup_load), .setup_word(setup_word),
    .view_ack(view_ack), .view_wr_en(view_wr_en), .view_wr_val(view_wr_val),
    .train_en(train_en), .xlat_en(xlat_en)
  );

  pcie_cfg_view_xfer #(.SYNC_STAGES(SYNC_STAGES)) i_view (
    .clk(clk), .rst(rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .wr_en(view_wr_en), .wr_val(view_wr_val),
    .view_ack(view_ack), .busy(view_busy), .view_dst(view_sel_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) link_up <= 1'b0;
    else     link_up <= (link_state == LINK_L0);
  end

endmodule

// File: rtl/pcie_cfg_router_chk.sv
module pcie_cfg_router_chk
  import pcie_cfg_router_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               loc_valid,
  input logic               rem_valid,
  input logic [ROUTE_W-1:0] rem_route,
  input logic               reg_valid,
  input logic               reg_write,
  input logic               reg_rvalid,
  input logic               view_ack,
  input logic               view_busy,
  input logic [4:0]         link_state,
  input logic               link_up
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(loc_valid && rem_valid)); // R1

  AST_REMOTE_BUS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rem_valid |-> (rem_route[23:16] != 8'd0)); // R2

  AST_TYPE_FLAG: assert property (@(posedge clk) disable iff (rst)
    rem_valid |-> (rem_route[24] == (rem_route[23:16] != 8'd1))); // R3

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rem_valid |-> (rem_route[31:25] == 7'd0 && rem_route[15:13] == 3'd0
                   && rem_route[7:3] == 5'd0)); // R3

  AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (rst)
    !rem_valid |-> $stable(rem_route)); // R5

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    !$stable(view_ack) |-> $past(view_busy)); // R8

  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    link_up == $past(link_state == LINK_UP_CODE)); // R10

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid == $past(reg_valid && !reg_write)); // R11

endmodule

bind pcie_cfg_router pcie_cfg_router_chk i_chk (
  .clk(clk), .rst(rst), .loc_valid(loc_valid), .rem_valid(rem_valid),
  .rem_route(rem_route), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_rvalid(reg_rvalid), .view_ack(view_ack), .view_busy(view_busy),
  .link_state(link_state), .link_up(link_up)
);

// File: tb/test_pcie_cfg_router.sv
`timescale 1ns/1ps
module test_pcie_cfg_router;

  logic        clk = 1'b0, dst_clk = 1'b0, rst = 1'b1, dst_rst = 1'b1;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        ca_valid = 1'b0, ca_write = 1'b0;
  logic [7:0]  ca_bus = '0;
  logic [4:0]  ca_dev = '0;
  logic [2:0]  ca_func = '0;
  logic [11:0] ca_off = '0;
  logic [31:0] ca_wdata = '0;
  logic        loc_valid, loc_write, rem_valid, rem_write;
  logic [12:0] loc_addr, rem_addr;
  logic [31:0] loc_wdata, rem_wdata, rem_route;
  logic        train_en, xlat_en, view_sel_dst, link_up;
  logic [4:0]  link_state = '0;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;
  always #3.5 dst_clk = ~dst_clk;

  pcie_cfg_router i_pcie_cfg_router (.*);

  // {bus, dev, func, off, write, local, expected route}
  localparam int NV = 7;
  localparam logic [61:0] VEC [NV] = '{
    {8'd0,   5'd3,  3'd1, 12'h010, 1'b1, 1'b1, 32'h0000_0000},
    {8'd1,   5'd0,  3'd0, 12'h000, 1'b0, 1'b0, 32'h0001_0000},
    {8'd2,   5'd5,  3'd2, 12'h004, 1'b1, 1'b0, 32'h0102_0502},
    {8'd0,   5'd31, 3'd7, 12'hFFC, 1'b0, 1'b1, 32'h0000_0000},
    {8'hFF,  5'd31, 3'd7, 12'hFFC, 1'b1, 1'b0, 32'h01FF_1F07},
    {8'd1,   5'd31, 3'd7, 12'h100, 1'b0, 1'b0, 32'h0001_1F07},
    {8'h10,  5'd0,  3'd3, 12'h728, 1'b1, 1'b0, 32'h0110_0003}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ca_go(input logic [7:0] b, input logic [4:0] dv, input logic [2:0] f,
                       input logic [11:0] o, input logic w, input logic [31:0] wd);
    @(negedge clk);
    ca_valid = 1'b1; ca_bus = b; ca_dev = dv; ca_func = f; ca_off = o;
    ca_write = w; ca_wdata = wd;
    @(negedge clk);
    ca_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_setup, exp_route;
    logic [61:0] v;
    int polls;

    repeat (6) @(negedge clk);
    rst = 1'b0; dst_rst = 1'b0;

    // R11: reset state
    chk("R11 loc_valid after reset", {31'd0, loc_valid}, 32'd0);
    chk("R11 rem_valid after reset", {31'd0, rem_valid}, 32'd0);
    reg_rd(8'h04, rd);
    chk("R11 read valid", {31'd0, reg_rvalid}, 32'd1);
    chk("R11 cmd reset", rd, 32'd0);
    reg_rd(8'h08, rd);
    chk("R11 setup reset", rd, 32'd0);
    reg_rd(8'h0C, rd);
    chk("R11 unmapped read", rd, 32'd0);
    @(negedge clk);
    chk("R11 rvalid one cycle", {31'd0, reg_rvalid}, 32'd0);

    // R1..R4: vector walk
    exp_setup = 32'd0;
    exp_route = 32'd0;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      ca_go(v[61:54], v[53:49], v[48:46], v[45:34], v[33], 32'hA500_0000 | i);
      if (v[32]) begin
        chk("R1 loc_valid", {31'd0, loc_valid}, 32'd1);
        chk("R1 no remote", {31'd0, rem_valid}, 32'd0);
        chk("R1 loc_addr", {19'd0, loc_addr}, {20'd0, v[45:34]});
        chk("R1 loc_write", {31'd0, loc_write}, {31'd0, v[33]});
        chk("R1 loc_wdata", loc_wdata, 32'hA500_0000 | i);
      end else begin
        exp_setup = v[31:0];
        exp_route = v[31:0];
        chk("R2 rem_valid", {31'd0, rem_valid}, 32'd1);
        chk("R2 no local", {31'd0, loc_valid}, 32'd0);
        chk("R2 rem_addr", {19'd0, rem_addr}, 32'h1000 + {20'd0, v[45:34]});
        chk("R2 rem_write", {31'd0, rem_write}, {31'd0, v[33]});
        chk("R3 rem_route", rem_route, v[31:0]);
      end
      reg_rd(8'h08, rd);
      chk("R4 setup after request", rd, exp_setup);
      chk("R1 strobe is one cycle", {30'd0, loc_valid, rem_valid}, 32'd0);
    end

    // R5 and R6: bus write to setup does not disturb the in-flight word
    reg_wr(8'h08, 32'hDEAD_BEEF);
    chk("R5 route held", rem_route, exp_route);
    chk("R5 no strobe", {31'd0, rem_valid}, 32'd0);
    reg_rd(8'h08, rd);
    chk("R6 setup write", rd, 32'hDEAD_BEEF);

    // R6: same-cycle collision, request wins
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h1234_5678;
    ca_valid = 1'b1; ca_bus = 8'd3; ca_dev = 5'd1; ca_func = 3'd0; ca_off = 12'h0;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; ca_valid = 1'b0;
    chk("R3 route bus3", rem_route, 32'h0103_0100);
    reg_rd(8'h08, rd);
    chk("R6 collision keeps request word", rd, 32'h0103_0100);

    // R10: link-up decode
    @(negedge clk); link_state = 5'h11;
    @(negedge clk); chk("R10 link up", {31'd0, link_up}, 32'd1);
    link_state = 5'h10;
    @(negedge clk); chk("R10 link down 0x10", {31'd0, link_up}, 32'd0);
    link_state = 5'h01;
    @(negedge clk); chk("R10 link down 0x01", {31'd0, link_up}, 32'd0);

    // R7: plain control bits
    reg_wr(8'h04, 32'hFFFF_FFDF);
    reg_rd(8'h04, rd);
    chk("R7 cmd readback", rd, 32'h0000_0003);
    chk("R7 enables", {30'd0, xlat_en, train_en}, 32'd3);
    reg_wr(8'h04, 32'h0000_0001);
    reg_rd(8'h04, rd);
    chk("R7 cmd readback 2", rd, 32'h0000_0001);
    chk("R7 xlat off", {31'd0, xlat_en}, 32'd0);

    // R8 and R9: alternate view crossing
    reg_wr(8'h04, 32'h0000_0021);
    reg_rd(8'h04, rd);
    chk("R8 bit5 not yet acknowledged", rd, 32'h0000_0001);
    reg_wr(8'h04, 32'h0000_0002);
    polls = 0;
    do begin
      reg_rd(8'h04, rd);
      polls++;
    end while (rd[5] !== 1'b1 && polls < 40);
    chk("R9 pending write ignored for bit5, others taken", rd, 32'h0000_0022);
    chk("R8 destination view set", {31'd0, view_sel_dst}, 32'd1);
    reg_wr(8'h04, 32'h0000_0002);
    polls = 0;
    do begin
      reg_rd(8'h04, rd);
      polls++;
    end while (rd[5] !== 1'b0 && polls < 40);
    chk("R8 view cleared readback", rd, 32'h0000_0002);
    chk("R8 destination view cleared", {31'd0, view_sel_dst}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule